// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial-bus slave that owns one 8-bit control byte. The upper five bits of the byte feed an external converter as a code. The lower three bits set three digital output levels. A bus master changes the byte with a fixed three-byte write and reads it back with a fixed three-byte read.

The block runs on a fast system clock. It brings both bus lines through synchronizers and detects their edges there. It pulls the data line low through an open-drain enable and never drives it high. The block always answers the same transaction shapes. It has no clock stretching, no general call and no register addressing beyond the single command byte.

Top module: `twowire_ctl_slave`

## Requirements
- R1: After reset the control byte is 00h, so `dac_code` is 0 and `out_lvl` is 0. `sda_oe` is low.
- R2: `dac_code` equals control bits [7:3] and `out_lvl[i]` equals control bit i for i = 0..2. A 1 bit means a high level.
- R3: The first byte after a START is acknowledged only when its upper seven bits equal 0101100b, which gives 58h for a write and 59h for a read. After any other address the slave drives nothing until the next START.
- R4: A write is START, 58h, AAh, data, STOP, sent MSB first. The slave acknowledges all three bytes, and the control byte then holds the data.
- R5: In a write, a command byte other than AAh gets no acknowledge. The data byte that follows is not acknowledged either, and the control byte keeps its value.
- R6: A read is START, 59h, then two bytes from the slave, MSB first: first 00h, then the control byte. The master acknowledges each of the two bytes.
- R7: If the master does not acknowledge the 00h byte, the slave releases the data line for the rest of the transfer. Eight further clocks then read FFh.
- R8: The control byte and its outputs change only on the SCL falling edge that ends the acknowledge of the data byte. While SCL is high in that acknowledge clock they still show the old value.
- R9: A STOP or START that arrives in the middle of a data byte ends the transfer without a change to the control byte. A START in that position begins a new transaction, and that transaction is served normally.
- R10: The slave changes its drive on the data line only while SCL is low. It samples on SCL rising edges and drives the acknowledge low for the whole 9th clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| dac_code | output | DAC_W | Converter code, control bits [7:3] |
| out_lvl | output | OUT_W | Digital output levels, control bits [2:0] |

## Verification
The SCL falling edge that ends the data-byte acknowledge does two things in the same few system cycles: it releases the data line and it commits the new control byte. A slip in either one shows as a stuck line or an early update. Back-to-back writes provoke this edge many times. The bench samples the outputs while SCL is high in the acknowledge clock, where they must still hold the old value, and again after the STOP, where they must hold the new one. It also checks that the line reads high on the next master-driven bit, which covers the release.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int BYTE_W  = 8;
   localparam int BIT_CW  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_DONE
   } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   // idle bus level is high, so the chain resets to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  =  chain_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
   input  logic scl_lvl,
   input  logic sda_rise,
   input  logic sda_fall,
   output logic start_o,
   output logic stop_o
);
   // data edges while the clock is high are framing events
   assign start_o = scl_lvl & sda_fall;
   assign stop_o  = scl_lvl & sda_rise;
endmodule

// File: rtl/tw_xfer_fsm.sv
module tw_xfer_fsm
   import tw_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR  = 7'h2C,
   parameter logic [BYTE_W-1:0] WR_CMD    = 8'hAA,
   parameter logic [BYTE_W-1:0] RD_PREFIX = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic [BYTE_W-1:0] reg_q,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data
);
   localparam logic [BIT_CW-1:0] LAST_RX = BIT_CW'(BYTE_W);
   localparam logic [BIT_CW-1:0] LAST_TX = BIT_CW'(BYTE_W - 1);

   tw_state_e         state_q;
   logic [BIT_CW-1:0] bit_q;
   logic [1:0]        byte_q;
   logic [BYTE_W-1:0] sh_q;
   logic              rd_q;
   logic              mack_q;
   logic              oe_q;
   logic              accept;

   // byte 0: address, byte 1: command, byte 2: data (write path)
   always_comb begin
      unique case (byte_q)
         2'd0:    accept = (sh_q[BYTE_W-1:1] == DEV_ADDR);
         2'd1:    accept = (sh_q == WR_CMD);
         default: accept = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         byte_q  <= '0;
         sh_q    <= '0;
         rd_q    <= 1'b0;
         mack_q  <= 1'b0;
         oe_q    <= 1'b0;
         wr_en   <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_i) begin
            state_q <= ST_RX;
            bit_q   <= '0;
            byte_q  <= '0;
            oe_q    <= 1'b0;
         end else if (stop_i) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               ST_RX: begin
                  if (scl_rise && bit_q != LAST_RX) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                     bit_q <= bit_q + 1'b1;
                  end else if (scl_fall && bit_q == LAST_RX) begin
                     if (accept) begin
                        oe_q    <= 1'b1;
                        state_q <= ST_RX_ACK;
                        if (byte_q == 2'd0) rd_q <= sh_q[0];
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     bit_q <= '0;
                     if (byte_q == 2'd0 && rd_q) begin
                        sh_q    <= RD_PREFIX;
                        oe_q    <= ~RD_PREFIX[BYTE_W-1];
                        byte_q  <= 2'd1;
                        state_q <= ST_TX;
                     end else if (byte_q == 2'd2) begin
                        oe_q    <= 1'b0;
                        wr_en   <= 1'b1;
                        state_q <= ST_DONE;
                     end else begin
                        oe_q    <= 1'b0;
                        byte_q  <= byte_q + 1'b1;
                        state_q <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_q == LAST_TX) begin
                        oe_q    <= 1'b0;
                        bit_q   <= '0;
                        state_q <= ST_TX_ACK;
                     end else begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                        oe_q  <= ~sh_q[BYTE_W-2];
                        bit_q <= bit_q + 1'b1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack_q && byte_q == 2'd1) begin
                        sh_q    <= reg_q;
                        oe_q    <= ~reg_q[BYTE_W-1];
                        byte_q  <= 2'd2;
                        state_q <= ST_TX;
                     end else begin
                        state_q <= ST_DONE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe  = oe_q;
   assign wr_data = sh_q;
endmodule

// File: rtl/tw_ctl_reg.sv
module tw_ctl_reg #(
   parameter int              DAC_W     = 5,
   parameter int              OUT_W     = 3,
   parameter logic [7:0]      RESET_VAL = 8'h00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [DAC_W+OUT_W-1:0] wr_data,
   output logic [DAC_W+OUT_W-1:0] reg_q,
   output logic [DAC_W-1:0]       dac_code,
   output logic [OUT_W-1:0]       out_lvl
);
   localparam int REG_W = DAC_W + OUT_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reg_q <= RESET_VAL[REG_W-1:0];
      else if (wr_en) reg_q <= wr_data;
   end

   assign dac_code = reg_q[REG_W-1:OUT_W];

   for (genvar i = 0; i < OUT_W; i++) begin : g_lvl
      assign out_lvl[i] = reg_q[i];
   end
endmodule

// File: rtl/twowire_ctl_slave.sv
module twowire_ctl_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter logic [7:0] WR_CMD      = 8'hAA,
   parameter logic [7:0] RD_PREFIX   = 8'h00,
   parameter int         DAC_W       = 5,
   parameter int         OUT_W       = 3,
   parameter logic [7:0] RESET_VAL   = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [DAC_W-1:0] dac_code,
   output logic [OUT_W-1:0] out_lvl
);
   import tw_pkg::*;

   localparam int REG_W   = DAC_W + OUT_W;
   localparam int N_LINES = 2;
   localparam int IDX_SCL = 0;
   localparam int IDX_SDA = 1;

   if (REG_W != BYTE_W) begin : g_bad_width
      $error("control fields must fill exactly one byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are required");
   end

   logic [N_LINES-1:0] raw_w, lvl_w, rise_w, fall_w;
   logic               start_w, stop_w, wr_en_w;
   logic [REG_W-1:0]   wr_data_w, reg_w;

   assign raw_w[IDX_SCL] = scl_i;
   assign raw_w[IDX_SDA] = sda_i;

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (raw_w[g]),
         .level_o (lvl_w[g]),
         .rise_o  (rise_w[g]),
         .fall_o  (fall_w[g])
      );
   end

   tw_bus_cond u_cond (
      .scl_lvl  (lvl_w[IDX_SCL]),
      .sda_rise (rise_w[IDX_SDA]),
      .sda_fall (fall_w[IDX_SDA]),
      .start_o  (start_w),
      .stop_o   (stop_w)
   );

   tw_xfer_fsm #(
      .DEV_ADDR  (DEV_ADDR),
      .WR_CMD    (WR_CMD),
      .RD_PREFIX (RD_PREFIX)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_w),
      .stop_i   (stop_w),
      .scl_rise (rise_w[IDX_SCL]),
      .scl_fall (fall_w[IDX_SCL]),
      .sda_lvl  (lvl_w[IDX_SDA]),
      .reg_q    (reg_w),
      .sda_oe   (sda_oe),
      .wr_en    (wr_en_w),
      .wr_data  (wr_data_w)
   );

   tw_ctl_reg #(
      .DAC_W     (DAC_W),
      .OUT_W     (OUT_W),
      .RESET_VAL (RESET_VAL)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_w),
      .wr_data  (wr_data_w),
      .reg_q    (reg_w),
      .dac_code (dac_code),
      .out_lvl  (out_lvl)
   );
endmodule

// File: rtl/twowire_ctl_slave_chk.sv
module twowire_ctl_slave_chk #(
   parameter int DAC_W = 5,
   parameter int OUT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_oe,
   input logic [DAC_W-1:0] dac_code,
   input logic [OUT_W-1:0] out_lvl
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (dac_code == '0 && out_lvl == '0));

   // R10
   drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);

   // R8
   commit_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({dac_code, out_lvl}) |-> !scl_i);

   // R8
   commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({dac_code, out_lvl}) |-> $past(sda_oe, 2));
endmodule

bind twowire_ctl_slave twowire_ctl_slave_chk #(.DAC_W(DAC_W), .OUT_W(OUT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe   (sda_oe),
   .dac_code (dac_code),
   .out_lvl  (out_lvl)
);

// File: tb/twowire_ctl_slave_tb.sv
module twowire_ctl_slave_tb;
   localparam int T = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   logic [4:0] dac_code;
   logic [2:0] out_lvl;
   logic sda_line;
   int tests = 0;
   int fails = 0;
   logic [7:0] model = 8'h00;

   always #2.5 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   twowire_ctl_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .dac_code(dac_code), .out_lvl(out_lvl));

   function automatic logic [7:0] outs_of(input logic [7:0] r);
      return {r[7:3], r[2:0]};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(T);
      m_scl = 1'b1; tick(T);
      m_sda = 1'b0; tick(T);
      m_scl = 1'b0; tick(T);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(T);
      m_scl = 1'b1; tick(T);
      m_sda = 1'b1; tick(T);
   endtask

   task automatic clock_bit(input logic b, output logic seen);
      m_sda = b;    tick(T);
      m_scl = 1'b1; tick(T);
      seen = sda_line; tick(T);
      m_scl = 1'b0; tick(T);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack, output logic [7:0] snap);
      logic seen;
      for (int i = 7; i >= 0; i--) clock_bit(b[i], seen);
      m_sda = 1'b1; tick(T);
      m_scl = 1'b1; tick(T);
      ack  = ~sda_line;
      snap = {dac_code, out_lvl};
      tick(T);
      m_scl = 1'b0; tick(T);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      logic seen;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, seen);
         b[i] = seen;
      end
      clock_bit(~mack, seen);
   endtask

   task automatic check_outs(input string req);
      chk(req, "dac_code", 32'(dac_code), 32'(model[7:3]));
      chk(req, "out_lvl",  32'(out_lvl),  32'(model[2:0]));
   endtask

   // full write; acks and result judged against the model
   task automatic wr_txn(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d);
      logic ka, kc, kd;
      logic [7:0] snap;
      logic a_ok, c_ok;
      a_ok = (a == 8'h58);
      c_ok = a_ok && (c == 8'hAA);
      bus_start();
      send_byte(a, ka, snap);
      send_byte(c, kc, snap);
      send_byte(d, kd, snap);
      chk("R3", "address ack", 32'(ka), 32'(a_ok));
      chk(a_ok ? "R5" : "R3", "command ack", 32'(kc), 32'(c_ok));
      chk(c_ok ? "R10" : "R5", "data ack", 32'(kd), 32'(c_ok));
      chk("R8", "outputs during data ack", 32'(snap), 32'(outs_of(model)));
      bus_stop();
      if (c_ok) model = d;
      check_outs(c_ok ? "R4" : "R5");
   endtask

   task automatic rd_txn(input logic nack_first);
      logic ka;
      logic [7:0] snap, b0, b1;
      bus_start();
      send_byte(8'h59, ka, snap);
      recv_byte(~nack_first, b0);
      recv_byte(1'b1, b1);
      bus_stop();
      chk("R6", "read address ack", 32'(ka), 32'd1);
      chk("R6", "prefix byte", 32'(b0), 32'h00);
      if (nack_first) chk("R7", "released after nack", 32'(b1), 32'hFF);
      else            chk("R6", "register byte", 32'(b1), 32'(model));
      chk("R6", "line released after read", 32'(sda_oe), 32'd0);
   endtask

   task automatic abort_txn(input int nbits, input logic restart,
                            input logic [7:0] part, input logic [7:0] nd);
      logic ka, seen;
      logic [7:0] snap;
      bus_start();
      send_byte(8'h58, ka, snap);
      send_byte(8'hAA, ka, snap);
      for (int i = 0; i < nbits; i++) clock_bit(part[7-i], seen);
      if (restart) begin
         bus_start();
         send_byte(8'h58, ka, snap);
         chk("R9", "restart address ack", 32'(ka), 32'd1);
         send_byte(8'hAA, ka, snap);
         send_byte(nd, ka, snap);
         chk("R9", "restart data ack", 32'(ka), 32'd1);
         bus_stop();
         model = nd;
      end else begin
         bus_stop();
      end
      check_outs("R9");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd24681);
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk("R1", "dac_code after reset", 32'(dac_code), 32'd0);
      chk("R1", "out_lvl after reset", 32'(out_lvl), 32'd0);
      chk("R1", "sda_oe after reset", 32'(sda_oe), 32'd0);

      // directed corners
      wr_txn(8'h58, 8'hAA, 8'hF8);          // R2: full code, outputs low
      chk("R2", "code all ones", 32'(dac_code), 32'h1F);
      wr_txn(8'h58, 8'hAA, 8'h05);          // R2: per-pin levels
      chk("R2", "pin 0 high", 32'(out_lvl[0]), 32'd1);
      chk("R2", "pin 1 low", 32'(out_lvl[1]), 32'd0);
      rd_txn(1'b0);
      wr_txn(8'h5A, 8'hAA, 8'h77);          // R3: wrong address
      wr_txn(8'hD8, 8'hAA, 8'h66);          // R3: msb differs
      wr_txn(8'h58, 8'hAB, 8'h33);          // R5: wrong command
      abort_txn(4, 1'b0, 8'h9C, 8'h00);     // R9: stop mid-byte
      abort_txn(6, 1'b1, 8'h00, 8'hC3);     // R9: restart mid-byte
      rd_txn(1'b1);                         // R7
      rd_txn(1'b0);

      for (int n = 0; n < 40; n++) begin
         int kind;
         logic [7:0] d;
         kind = int'($urandom_range(0, 4));
         d    = 8'($urandom());
         case (kind)
            0, 1: wr_txn(8'h58, 8'hAA, d);
            2:    rd_txn(1'($urandom_range(0, 1)));
            3:    wr_txn(8'h58, (d[0] ? 8'hAA : 8'h2A) ^ {7'h0, d[1]}, d);
            default: abort_txn(int'($urandom_range(1, 7)), 1'($urandom_range(0, 1)), d, ~d);
         endcase
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule